// File: doc/BRIEF.md
# Lockable Address Translation Entry Array

This block holds a small set of address translation entries that software loads and pins in place. It is fully associative. Software prepares an entry in two 32-bit staging registers. The virtual word carries the page number, a global flag and an address-space ID. The physical word carries the physical page, two security bits and a region size code. A commit strobe with a slot index then copies the staged pair into that slot and marks the slot valid. A per-slot invalidate input clears any slot.

The lookup port is combinational. It takes a 32-bit virtual address, the current address-space ID and the current security state. It returns a hit flag, the translated physical address and the non-secure access attribute of the matching entry.

Each entry describes a 4 KB page, a 64 KB page, a 1 MB section or a 16 MB supersection, so each slot applies its own compare mask. The address bits below the region boundary pass straight from the virtual address to the physical address. When several slots match, the lowest-numbered slot supplies the result and a multi-hit flag is raised.

Top module: `tlb_lock_array`

## Requirements
- R1: The virtual staging word loads on the clock edge where its write enable is high. Its layout is: virtual page number in bits [31:12], global flag in bit 9, address-space ID in bits [7:0]. Bits [11:10] and bit 8 are ignored.
- R2: An entry whose global flag is 0 hits only when its stored address-space ID equals the lookup ID. An entry whose global flag is 1 hits for every lookup ID.
- R3: The physical staging word loads on the clock edge where its write enable is high. Its layout is: physical page in bits [31:12], non-secure access attribute in bit 9, non-secure entry flag in bit 8, size code in bits [7:6]. The size code is 00 = 16 MB, 01 = 4 KB, 10 = 64 KB and 11 = 1 MB. The virtual address compare then covers bits [31:24], [31:12], [31:16] or [31:20] respectively.
- R4: On a hit, the physical address takes the stored physical page bits above the region boundary and the lookup address bits below it. The page bits written below the boundary, and the virtual page bits below it, have no effect.
- R5: When the non-secure entry flag is written as 1, the stored non-secure access attribute is 1 whatever was written for it. A secure entry keeps the written attribute, including 1.
- R6: An entry with the non-secure entry flag at 0 hits only when the lookup is made in the secure state (lookup security input 0). An entry with the flag at 1 hits only in the non-secure state (input 1).
- R7: A commit writes the staged pair into the indexed slot and makes it valid from the next clock edge. Before that edge the slot does not hit. A high bit of the invalidate input clears that slot's valid bit on the edge. When a commit and an invalidate target the same slot in the same cycle, the invalidate wins.
- R8: When more than one valid entry matches, the outputs come from the lowest-numbered matching slot and the multi-hit flag is 1. With a single match the multi-hit flag is 0.
- R9: A synchronous active-high reset clears every valid bit. On a miss, the hit flag, physical address, attribute and multi-hit flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stage_va_we | input | 1 | Load the virtual staging word |
| stage_va_wdata | input | 32 | Virtual staging word data |
| stage_pa_we | input | 1 | Load the physical staging word |
| stage_pa_wdata | input | 32 | Physical staging word data |
| commit_en | input | 1 | Copy the staged pair into a slot |
| commit_slot | input | 3 | Slot index for the commit |
| inval_mask | input | 8 | Per-slot invalidate, one bit per slot |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Current address-space ID |
| lk_nonsec | input | 1 | Lookup security state, 1 = non-secure |
| hit | output | 1 | A valid entry matched |
| hit_pa | output | 32 | Translated physical address |
| hit_nsa | output | 1 | Non-secure access attribute of the match |
| multi_hit | output | 1 | More than one valid entry matched |

## Verification
The assertions assume that the commit index always names an existing slot. They also assume that the lookup inputs are steady around each rising edge, because the result is combinational and is sampled there. The bench changes every input on the falling edge only. It never writes a staging register in the same cycle as a commit, so each commit takes a staged pair that has settled. Overlapping regions are set up only on purpose, in the priority test. Every other entry gets its own address range.

// File: rtl/tlb_lock_pkg.sv
package tlb_lock_pkg;

  localparam int WORD_W   = 32;
  localparam int PAGE_LSB = 12;
  localparam int PAGE_W   = WORD_W - PAGE_LSB;
  localparam int ASID_W   = 8;

  // Staging word field positions (software visible)
  localparam int VW_GLOBAL   = 9;
  localparam int PW_NSA      = 9;
  localparam int PW_NSENTRY  = 8;
  localparam int PW_SIZE_HI  = 7;
  localparam int PW_SIZE_LO  = 6;

  typedef enum logic [1:0] {
    SZ_16M = 2'b00,
    SZ_4K  = 2'b01,
    SZ_64K = 2'b10,
    SZ_1M  = 2'b11
  } region_size_e;

  typedef struct packed {
    logic [PAGE_W-1:0] vpn;
    logic              global_en;
    logic [ASID_W-1:0] asid;
    logic [PAGE_W-1:0] ppn;
    logic              nsa;
    logic              nonsec_entry;
    region_size_e      size;
  } tlb_entry_t;

  // Mask over the page-number bits that take part in the compare
  function automatic logic [PAGE_W-1:0] page_mask(region_size_e s);
    logic [PAGE_W-1:0] m;
    case (s)
      SZ_16M:  m = {{8{1'b1}},  {12{1'b0}}};
      SZ_64K:  m = {{16{1'b1}}, {4{1'b0}}};
      SZ_1M:   m = {{12{1'b1}}, {8{1'b0}}};
      default: m = {PAGE_W{1'b1}};
    endcase
    return m;
  endfunction

endpackage

// File: rtl/tlb_stage_regs.sv
module tlb_stage_regs
  import tlb_lock_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              va_we,
  input  logic [WORD_W-1:0] va_wdata,
  input  logic              pa_we,
  input  logic [WORD_W-1:0] pa_wdata,
  output tlb_entry_t        staged
);

  logic [PAGE_W-1:0] vpn_q;
  logic              glob_q;
  logic [ASID_W-1:0] asid_q;
  logic [PAGE_W-1:0] ppn_q;
  logic              nsa_q;
  logic              nse_q;
  region_size_e      size_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vpn_q  <= '0;
      glob_q <= 1'b0;
      asid_q <= '0;
    end else if (va_we) begin
      vpn_q  <= va_wdata[WORD_W-1:PAGE_LSB];
      glob_q <= va_wdata[VW_GLOBAL];
      asid_q <= va_wdata[ASID_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ppn_q  <= '0;
      nsa_q  <= 1'b0;
      nse_q  <= 1'b0;
      size_q <= SZ_16M;
    end else if (pa_we) begin
      ppn_q  <= pa_wdata[WORD_W-1:PAGE_LSB];
      // a non-secure entry can only reach non-secure memory
      nsa_q  <= pa_wdata[PW_NSA] | pa_wdata[PW_NSENTRY];
      nse_q  <= pa_wdata[PW_NSENTRY];
      size_q <= region_size_e'(pa_wdata[PW_SIZE_HI:PW_SIZE_LO]);
    end
  end

  always_comb begin
    staged.vpn          = vpn_q;
    staged.global_en    = glob_q;
    staged.asid         = asid_q;
    staged.ppn          = ppn_q;
    staged.nsa          = nsa_q;
    staged.nonsec_entry = nse_q;
    staged.size         = size_q;
  end

  logic unused_stage_bits;
  assign unused_stage_bits = ^{va_wdata[11:10], va_wdata[8],
                               pa_wdata[11:10], pa_wdata[5:0]};

endmodule

// File: rtl/tlb_slot_store.sv
module tlb_slot_store
  import tlb_lock_pkg::*;
#(
  parameter int N_SLOTS = 8,
  parameter int SLOT_W  = $clog2(N_SLOTS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    commit_en,
  input  logic [SLOT_W-1:0]       commit_slot,
  input  tlb_entry_t              entry_in,
  input  logic [N_SLOTS-1:0]      inval_mask,
  output tlb_entry_t [N_SLOTS-1:0] entries,
  output logic [N_SLOTS-1:0]      valid
);

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    logic       wr_hit;
    tlb_entry_t data_q;
    logic       valid_q;

    assign wr_hit = commit_en && (commit_slot == SLOT_W'(s));

    // entry contents carry no reset so the array maps onto plain storage
    always_ff @(posedge clk) begin
      if (wr_hit) data_q <= entry_in;
    end

    always_ff @(posedge clk) begin
      if (rst)                valid_q <= 1'b0;
      else if (inval_mask[s]) valid_q <= 1'b0;
      else if (wr_hit)        valid_q <= 1'b1;
    end

    assign entries[s] = data_q;
    assign valid[s]   = valid_q;
  end

endmodule

// File: rtl/tlb_match_unit.sv
module tlb_match_unit
  import tlb_lock_pkg::*;
(
  input  tlb_entry_t        entry,
  input  logic              valid,
  input  logic [WORD_W-1:0] lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_nonsec,
  output logic              match
);

  logic [PAGE_W-1:0] mask;
  logic              page_eq;
  logic              asid_ok;
  logic              sec_ok;

  always_comb begin
    mask    = page_mask(entry.size);
    page_eq = ((lk_va[WORD_W-1:PAGE_LSB] ^ entry.vpn) & mask) == '0;
    asid_ok = entry.global_en || (entry.asid == lk_asid);
    sec_ok  = (entry.nonsec_entry == lk_nonsec);
    match   = valid && page_eq && asid_ok && sec_ok;
  end

  logic unused_match_bits;
  assign unused_match_bits = ^{entry.ppn, entry.nsa};

endmodule

// File: rtl/tlb_hit_select.sv
module tlb_hit_select
  import tlb_lock_pkg::*;
#(
  parameter int N_SLOTS = 8,
  parameter int SLOT_W  = $clog2(N_SLOTS),
  parameter int CNT_W   = $clog2(N_SLOTS + 1)
) (
  input  logic [N_SLOTS-1:0]       match,
  input  tlb_entry_t [N_SLOTS-1:0] entries,
  input  logic [WORD_W-1:0]        lk_va,
  output logic                     hit,
  output logic [WORD_W-1:0]        hit_pa,
  output logic                     hit_nsa,
  output logic                     multi_hit
);

  logic [SLOT_W-1:0] sel;
  logic [CNT_W-1:0]  n_match;
  tlb_entry_t        win;
  logic [PAGE_W-1:0] mask;

  always_comb begin
    sel = '0;
    hit = 1'b0;
    for (int i = N_SLOTS - 1; i >= 0; i--) begin
      if (match[i]) begin
        sel = SLOT_W'(i);
        hit = 1'b1;
      end
    end
  end

  always_comb begin
    n_match = '0;
    for (int i = 0; i < N_SLOTS; i++) n_match = n_match + CNT_W'(match[i]);
  end

  always_comb begin
    win       = entries[sel];
    mask      = page_mask(win.size);
    multi_hit = (n_match > CNT_W'(1));
    if (hit) begin
      hit_pa  = {(win.ppn & mask) | (lk_va[WORD_W-1:PAGE_LSB] & ~mask),
                 lk_va[PAGE_LSB-1:0]};
      hit_nsa = win.nsa;
    end else begin
      hit_pa  = '0;
      hit_nsa = 1'b0;
    end
  end

endmodule

// File: rtl/tlb_lock_array.sv
module tlb_lock_array
  import tlb_lock_pkg::*;
#(
  parameter int N_SLOTS = 8,
  parameter int SLOT_W  = $clog2(N_SLOTS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stage_va_we,
  input  logic [31:0]        stage_va_wdata,
  input  logic               stage_pa_we,
  input  logic [31:0]        stage_pa_wdata,
  input  logic               commit_en,
  input  logic [SLOT_W-1:0]  commit_slot,
  input  logic [N_SLOTS-1:0] inval_mask,
  input  logic [31:0]        lk_va,
  input  logic [7:0]         lk_asid,
  input  logic               lk_nonsec,
  output logic               hit,
  output logic [31:0]        hit_pa,
  output logic               hit_nsa,
  output logic               multi_hit
);

  tlb_entry_t                staged;
  tlb_entry_t [N_SLOTS-1:0]  entries;
  logic [N_SLOTS-1:0]        slot_valid;
  logic [N_SLOTS-1:0]        slot_match;

  tlb_stage_regs u_stage (
    .clk      (clk),
    .rst      (rst),
    .va_we    (stage_va_we),
    .va_wdata (stage_va_wdata),
    .pa_we    (stage_pa_we),
    .pa_wdata (stage_pa_wdata),
    .staged   (staged)
  );

  tlb_slot_store #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W)) u_store (
    .clk         (clk),
    .rst         (rst),
    .commit_en   (commit_en),
    .commit_slot (commit_slot),
    .entry_in    (staged),
    .inval_mask  (inval_mask),
    .entries     (entries),
    .valid       (slot_valid)
  );

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_cmp
    tlb_match_unit u_match (
      .entry     (entries[s]),
      .valid     (slot_valid[s]),
      .lk_va     (lk_va),
      .lk_asid   (lk_asid),
      .lk_nonsec (lk_nonsec),
      .match     (slot_match[s])
    );
  end

  tlb_hit_select #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W)) u_sel (
    .match     (slot_match),
    .entries   (entries),
    .lk_va     (lk_va),
    .hit       (hit),
    .hit_pa    (hit_pa),
    .hit_nsa   (hit_nsa),
    .multi_hit (multi_hit)
  );

endmodule

// File: rtl/tlb_lock_array_chk.sv
module tlb_lock_array_chk #(
  parameter int N_SLOTS = 8,
  parameter int SLOT_W  = $clog2(N_SLOTS)
) (
  input logic               clk,
  input logic               rst,
  input logic               commit_en,
  input logic [SLOT_W-1:0]  commit_slot,
  input logic [N_SLOTS-1:0] inval_mask,
  input logic [N_SLOTS-1:0] slot_valid,
  input logic [31:0]        lk_va,
  input logic               lk_nonsec,
  input logic               hit,
  input logic [31:0]        hit_pa,
  input logic               hit_nsa,
  input logic               multi_hit
);

  AST_COMMIT_SETS_VALID: assert property (@(posedge clk) disable iff (rst)
    (commit_en && !inval_mask[commit_slot]) |=> slot_valid[$past(commit_slot)]); // R7

  AST_INVAL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (|inval_mask) |=> ((slot_valid & $past(inval_mask)) == '0)); // R7

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (slot_valid == '0)); // R9

  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (hit_pa == '0 && !hit_nsa && !multi_hit)); // R9

  AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    multi_hit |-> hit); // R8

  AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (rst)
    hit |-> (hit_pa[11:0] == lk_va[11:0])); // R4

  AST_NONSEC_FORCES_NSA: assert property (@(posedge clk) disable iff (rst)
    (hit && lk_nonsec) |-> hit_nsa); // R5

endmodule

bind tlb_lock_array tlb_lock_array_chk #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .commit_en   (commit_en),
  .commit_slot (commit_slot),
  .inval_mask  (inval_mask),
  .slot_valid  (slot_valid),
  .lk_va       (lk_va),
  .lk_nonsec   (lk_nonsec),
  .hit         (hit),
  .hit_pa      (hit_pa),
  .hit_nsa     (hit_nsa),
  .multi_hit   (multi_hit)
);

// File: tb/tlb_lock_array_bench.sv
module tlb_lock_array_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stage_va_we = 1'b0;
  logic [31:0] stage_va_wdata = '0;
  logic        stage_pa_we = 1'b0;
  logic [31:0] stage_pa_wdata = '0;
  logic        commit_en = 1'b0;
  logic [2:0]  commit_slot = '0;
  logic [7:0]  inval_mask = '0;
  logic [31:0] lk_va = '0;
  logic [7:0]  lk_asid = 8'h05;
  logic        lk_nonsec = 1'b0;
  logic        hit;
  logic [31:0] hit_pa;
  logic        hit_nsa;
  logic        multi_hit;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tlb_lock_array u_tlb_lock_array (
    .clk(clk), .rst(rst),
    .stage_va_we(stage_va_we), .stage_va_wdata(stage_va_wdata),
    .stage_pa_we(stage_pa_we), .stage_pa_wdata(stage_pa_wdata),
    .commit_en(commit_en), .commit_slot(commit_slot), .inval_mask(inval_mask),
    .lk_va(lk_va), .lk_asid(lk_asid), .lk_nonsec(lk_nonsec),
    .hit(hit), .hit_pa(hit_pa), .hit_nsa(hit_nsa), .multi_hit(multi_hit)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic load_slot(int slot, logic [31:0] vw, logic [31:0] pw);
    @(negedge clk);
    stage_va_we = 1'b1; stage_va_wdata = vw;
    stage_pa_we = 1'b1; stage_pa_wdata = pw;
    @(negedge clk);
    stage_va_we = 1'b0; stage_pa_we = 1'b0;
    commit_en = 1'b1; commit_slot = slot[2:0];
    @(negedge clk);
    commit_en = 1'b0;
  endtask

  task automatic look(logic [31:0] va, logic [7:0] asid, logic ns);
    @(negedge clk);
    lk_va = va; lk_asid = asid; lk_nonsec = ns;
    #1;
  endtask

  task automatic inval(logic [7:0] m);
    @(negedge clk);
    inval_mask = m;
    @(negedge clk);
    inval_mask = '0;
  endtask

  task automatic t_reset();
    look(32'h1234_5678, 8'h05, 1'b0);
    chk("R9 hit after reset", {31'b0, hit}, 32'd0);
    chk("R9 pa after reset", hit_pa, 32'd0);
    chk("R9 multi after reset", {31'b0, multi_hit}, 32'd0);
  endtask

  task automatic t_page4k();
    // R7: before the commit edge the slot must not hit
    @(negedge clk);
    stage_va_we = 1'b1; stage_va_wdata = 32'h1234_5005;
    stage_pa_we = 1'b1; stage_pa_wdata = 32'hABCD_E040;
    @(negedge clk);
    stage_va_we = 1'b0; stage_pa_we = 1'b0;
    lk_va = 32'h1234_5678; lk_asid = 8'h05; lk_nonsec = 1'b0;
    commit_en = 1'b1; commit_slot = 3'd0;
    #1;
    chk("R7 no hit before commit edge", {31'b0, hit}, 32'd0);
    @(negedge clk);
    commit_en = 1'b0;
    #1;
    chk("R7 hit after commit edge", {31'b0, hit}, 32'd1);
    chk("R1 R3 R4 4KB translation", hit_pa, 32'hABCD_E678);
    chk("R5 secure entry nsa kept 0", {31'b0, hit_nsa}, 32'd0);
    look(32'h1234_5678, 8'h06, 1'b0);
    chk("R2 asid mismatch misses", {31'b0, hit}, 32'd0);
    look(32'h1234_5678, 8'h05, 1'b1);
    chk("R6 secure entry misses in nonsecure state", {31'b0, hit}, 32'd0);
    look(32'h1234_6678, 8'h05, 1'b0);
    chk("R3 4KB compares bit 12", {31'b0, hit}, 32'd0);
  endtask

  task automatic t_global64k();
    load_slot(1, 32'h0045_0233, 32'h8765_0080);
    look(32'h0045_ABCD, 8'h77, 1'b0);
    chk("R2 global hits any asid", {31'b0, hit}, 32'd1);
    chk("R3 R4 64KB translation", hit_pa, 32'h8765_ABCD);
  endtask

  task automatic t_sections();
    load_slot(2, 32'h3000_0200, 32'h7F10_00C0);
    look(32'h300A_BCDE, 8'h01, 1'b0);
    chk("R3 R4 1MB translation", hit_pa, 32'h7F1A_BCDE);
    look(32'h301A_BCDE, 8'h01, 1'b0);
    chk("R3 1MB compares bit 20", {31'b0, hit}, 32'd0);
    load_slot(3, 32'h55AB_C200, 32'h99FF_F000);
    look(32'h5512_3456, 8'h01, 1'b0);
    chk("R3 R4 16MB ignores low page bits", hit_pa, 32'h9912_3456);
  endtask

  task automatic t_security();
    load_slot(4, 32'h6000_0200, 32'h1111_1140);
    look(32'h6000_0ABC, 8'h00, 1'b1);
    chk("R6 nonsecure entry hits nonsecure", {31'b0, hit}, 32'd1);
    chk("R5 forced nsa", {31'b0, hit_nsa}, 32'd1);
    chk("R4 nonsecure entry pa", hit_pa, 32'h1111_1ABC);
    look(32'h6000_0ABC, 8'h00, 1'b0);
    chk("R6 nonsecure entry misses secure", {31'b0, hit}, 32'd0);
    load_slot(5, 32'h6100_0200, 32'h2222_2240);
    look(32'h6100_0010, 8'h00, 1'b0);
    chk("R5 secure entry keeps nsa 1", {31'b0, hit_nsa}, 32'd1);
    chk("R4 secure nsa entry pa", hit_pa, 32'h2222_2010);
  endtask

  task automatic t_priority();
    load_slot(6, 32'h7000_0200, 32'h3333_3040);
    load_slot(7, 32'h7000_0200, 32'h4444_4040);
    look(32'h7000_0FFF, 8'h00, 1'b0);
    chk("R8 lowest slot wins", hit_pa, 32'h3333_3FFF);
    chk("R8 multi flag set", {31'b0, multi_hit}, 32'd1);
    inval(8'h40);
    look(32'h7000_0FFF, 8'h00, 1'b0);
    chk("R8 R7 remaining slot after invalidate", hit_pa, 32'h4444_4FFF);
    chk("R8 single match multi clear", {31'b0, multi_hit}, 32'd0);
  endtask

  task automatic t_invalidate();
    inval(8'h01);
    look(32'h1234_5678, 8'h05, 1'b0);
    chk("R7 invalidated slot misses", {31'b0, hit}, 32'd0);
    // commit and invalidate of the same slot together: invalidate wins
    @(negedge clk);
    stage_va_we = 1'b1; stage_va_wdata = 32'h1234_5005;
    stage_pa_we = 1'b1; stage_pa_wdata = 32'hABCD_E040;
    @(negedge clk);
    stage_va_we = 1'b0; stage_pa_we = 1'b0;
    commit_en = 1'b1; commit_slot = 3'd0; inval_mask = 8'h01;
    @(negedge clk);
    commit_en = 1'b0; inval_mask = '0;
    #1;
    chk("R7 invalidate beats commit", {31'b0, hit}, 32'd0);
  endtask

  task automatic t_reset_again();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    look(32'h300A_BCDE, 8'h01, 1'b0);
    chk("R9 reset clears 1MB slot", {31'b0, hit}, 32'd0);
    look(32'h7000_0FFF, 8'h00, 1'b0);
    chk("R9 reset clears priority slot", hit_pa, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_page4k();
    t_global64k();
    t_sections();
    t_security();
    t_priority();
    t_invalidate();
    t_reset_again();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule